// File: doc/BRIEF.md
# Universal Shift Register with Shared Parallel Bus

An eight-stage register that, on each rising clock edge, keeps its contents, moves them one place toward the high end, moves them one place toward the low end, or takes a new word from a bidirectional parallel bus. A two-bit mode input picks the operation. An active-low clear is sampled at the same edge and empties every stage, whatever the mode input says.

The parallel word both enters and leaves through one shared tri-state bus. The block drives the bus with its stage contents only when two active-low enables are both low and the mode is not load. In load mode the block releases the bus, so an outside agent can drive the new word without contention. Stage 0 and stage 7 also feed dedicated serial outputs that are never released. Each end has its own serial input, so several blocks can be chained into a longer register.

Top module: `univ_shreg`

## Requirements
- R1: With mode = 2'b00 (hold) and clear inactive, the stage contents do not change at the clock edge.
- R2: With mode = 2'b01 (move up), the value on `ser_in_up` enters stage 0 and stage n takes the old stage n-1 at the clock edge.
- R3: With mode = 2'b10 (move down), the value on `ser_in_dn` enters stage 7 and stage n takes the old stage n+1 at the clock edge.
- R4: With mode = 2'b11 (load), stage n takes `pbus[n]` at the clock edge.
- R5: When `clr_n` is low at a clock edge, all stages become 0 at that edge, for every mode value.
- R6: When `oe_a_n` and `oe_b_n` are both low and mode is not 2'b11, `pbus` carries the stage contents, bit n from stage n.
- R7: When either enable input is high, `pbus` is released to high impedance, and the stage contents still follow R1 to R3.
- R8: Whenever mode is 2'b11, `pbus` is released at once, before the capturing edge, whatever the enable inputs are.
- R9: `ser_out_lo` always shows stage 0 and `ser_out_hi` always shows stage 7, whatever the enables and the mode are.
- R10: A clear taken while the bus is enabled in a non-load mode makes `pbus` read all zeros right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every state change happens on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, overrides the mode |
| mode | input | 2 | 00 hold, 01 move up, 10 move down, 11 parallel load |
| ser_in_up | input | 1 | Serial bit entering stage 0 when moving up |
| ser_in_dn | input | 1 | Serial bit entering stage 7 when moving down |
| oe_a_n | input | 1 | First bus enable, active low |
| oe_b_n | input | 1 | Second bus enable, active low |
| pbus | inout | 8 | Shared parallel bus: load data in, stage contents out |
| ser_out_lo | output | 1 | Stage 0, always driven |
| ser_out_hi | output | 1 | Stage 7, always driven |

## Verification
Two operations can collide in one cycle: the clear and a mode operation (load or a move), and the bus output and an outside driver. The bench asserts the clear together with load and with a move, and expects zeros in every stage, read back on the bus and on both serial outputs. It also selects load with both enables low while the bus has only a pull-down: a zero reading against nonzero contents shows the drivers let go before the edge, and the loaded word arriving intact shows nothing fought the outside driver.

// File: rtl/shreg_pkg.sv
package shreg_pkg;
  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DN   = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;
endpackage

// File: rtl/shreg_next.sv
module shreg_next #(
  parameter int W = 8
) (
  input  logic [W-1:0] cur,
  input  logic         clr_n,
  input  logic [1:0]   mode,
  input  logic         ser_up,
  input  logic         ser_dn,
  input  logic [W-1:0] par_in,
  output logic [W-1:0] nxt,
  output logic         en
);
  import shreg_pkg::*;

  mode_e       m;
  logic [W-1:0] from_low;   // source when moving up
  logic [W-1:0] from_high;  // source when moving down

  assign m = mode_e'(mode);

  for (genvar i = 0; i < W; i++) begin : g_stage
    if (i == 0) begin : g_lo
      assign from_low[i] = ser_up;
    end else begin : g_lo_mid
      assign from_low[i] = cur[i-1];
    end
    if (i == W-1) begin : g_hi
      assign from_high[i] = ser_dn;
    end else begin : g_hi_mid
      assign from_high[i] = cur[i+1];
    end
  end

  // clock enable: only hold with clear released leaves the stages alone
  assign en = !clr_n || (m != MODE_HOLD);

  always_comb begin
    if (!clr_n) begin
      nxt = '0;
    end else begin
      unique case (m)
        MODE_UP:   nxt = from_low;
        MODE_DN:   nxt = from_high;
        MODE_LOAD: nxt = par_in;
        default:   nxt = cur;
      endcase
    end
  end
endmodule

// File: rtl/shreg_core.sv
module shreg_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (en) begin
      q <= d;
    end
  end
endmodule

// File: rtl/shreg_busdrv.sv
module shreg_busdrv (
  input  logic [1:0] mode,
  input  logic       oe_a_n,
  input  logic       oe_b_n,
  output logic       drive
);
  import shreg_pkg::*;

  logic load_sel;

  assign load_sel = (mode_e'(mode) == MODE_LOAD);
  assign drive    = !oe_a_n && !oe_b_n && !load_sel;
endmodule

// File: rtl/univ_shreg.sv
module univ_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   mode,
  input  logic         ser_in_up,
  input  logic         ser_in_dn,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  inout  wire  [W-1:0] pbus,
  output logic         ser_out_lo,
  output logic         ser_out_hi
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic         state_en;
  logic         bus_drive;

  shreg_next #(.W(W)) u_next (
    .cur    (state_q),
    .clr_n  (clr_n),
    .mode   (mode),
    .ser_up (ser_in_up),
    .ser_dn (ser_in_dn),
    .par_in (pbus),
    .nxt    (state_d),
    .en     (state_en)
  );

  shreg_core #(.W(W)) u_core (
    .clk (clk),
    .en  (state_en),
    .d   (state_d),
    .q   (state_q)
  );

  shreg_busdrv u_busdrv (
    .mode   (mode),
    .oe_a_n (oe_a_n),
    .oe_b_n (oe_b_n),
    .drive  (bus_drive)
  );

  assign pbus       = bus_drive ? state_q : {W{1'bz}};
  assign ser_out_lo = state_q[0];
  assign ser_out_hi = state_q[W-1];
endmodule

// File: rtl/univ_shreg_chk.sv
module univ_shreg_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         clr_n,
  input logic [1:0]   mode,
  input logic         ser_in_up,
  input logic         ser_in_dn,
  input logic         oe_a_n,
  input logic         oe_b_n,
  input logic [W-1:0] pbus,
  input logic         ser_out_lo,
  input logic         ser_out_hi,
  input logic [W-1:0] state
);
  // contents are known only after the first clear has been taken
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    if (!clr_n) armed <= 1'b1;
  end

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && mode == 2'b00) |=> $stable(state)); // R1
  AST_MOVE_UP: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && mode == 2'b01) |=> state == {$past(state[W-2:0]), $past(ser_in_up)}); // R2
  AST_MOVE_DN: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && mode == 2'b10) |=> state == {$past(ser_in_dn), $past(state[W-1:1])}); // R3
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && mode == 2'b11) |=> state == $past(pbus)); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> (state == '0 && !ser_out_lo && !ser_out_hi)); // R5
  AST_BUS_SHOWS: assert property (@(posedge clk) disable iff (!armed)
    (!oe_a_n && !oe_b_n && mode != 2'b11) |-> pbus == state); // R6
  AST_SERIAL_ENDS: assert property (@(posedge clk) disable iff (!armed)
    (ser_out_lo == state[0]) && (ser_out_hi == state[W-1])); // R9
endmodule

bind univ_shreg univ_shreg_chk #(.W(W)) u_chk (
  .clk        (clk),
  .clr_n      (clr_n),
  .mode       (mode),
  .ser_in_up  (ser_in_up),
  .ser_in_dn  (ser_in_dn),
  .oe_a_n     (oe_a_n),
  .oe_b_n     (oe_b_n),
  .pbus       (pbus),
  .ser_out_lo (ser_out_lo),
  .ser_out_hi (ser_out_hi),
  .state      (state_q)
);

// File: tb/test_univ_shreg.sv
`timescale 1ns/1ps
module test_univ_shreg;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       sup = 1'b0;
  logic       sdn = 1'b0;
  logic       oe_a_n = 1'b0;
  logic       oe_b_n = 1'b0;
  logic       ext_en = 1'b0;
  logic [7:0] ext_val = 8'h00;
  wire  [7:0] pbus;
  logic       s_lo;
  logic       s_hi;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  assign pbus = ext_en ? ext_val : 8'bzzzz_zzzz;
  for (genvar i = 0; i < 8; i++) begin : g_pd
    pulldown (pbus[i]);
  end

  univ_shreg i_univ_shreg (
    .clk        (clk),
    .clr_n      (clr_n),
    .mode       (mode),
    .ser_in_up  (sup),
    .ser_in_dn  (sdn),
    .oe_a_n     (oe_a_n),
    .oe_b_n     (oe_b_n),
    .pbus       (pbus),
    .ser_out_lo (s_lo),
    .ser_out_hi (s_hi)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // fields: clr_n, mode[1:0], ser_up, ser_dn, load word[7:0], expected[7:0]
  localparam logic [20:0] VEC [12] = '{
    {1'b0, 2'b11, 1'b0, 1'b0, 8'hA5, 8'h00},  // R5 clear beats load
    {1'b1, 2'b11, 1'b0, 1'b0, 8'hA5, 8'hA5},  // R4
    {1'b1, 2'b00, 1'b1, 1'b1, 8'h00, 8'hA5},  // R1
    {1'b1, 2'b01, 1'b1, 1'b0, 8'h00, 8'h4B},  // R2
    {1'b1, 2'b01, 1'b0, 1'b1, 8'h00, 8'h96},  // R2
    {1'b1, 2'b10, 1'b0, 1'b1, 8'h00, 8'hCB},  // R3
    {1'b1, 2'b10, 1'b1, 1'b0, 8'h00, 8'h65},  // R3
    {1'b1, 2'b11, 1'b1, 1'b1, 8'h3C, 8'h3C},  // R4
    {1'b0, 2'b01, 1'b1, 1'b1, 8'h00, 8'h00},  // R5 clear beats move
    {1'b1, 2'b01, 1'b1, 1'b0, 8'h00, 8'h01},  // R2
    {1'b1, 2'b10, 1'b1, 1'b0, 8'h00, 8'h00},  // R3
    {1'b1, 2'b11, 1'b0, 1'b0, 8'hFF, 8'hFF}   // R4
  };

  initial begin
    // reset state
    repeat (2) @(posedge clk);
    #1;
    check("R5 reset bus", pbus, 8'h00);
    check("R9 reset ends", {6'b0, s_hi, s_lo}, 8'h00);

    foreach (VEC[k]) begin
      @(negedge clk);
      clr_n   = VEC[k][20];
      mode    = VEC[k][19:18];
      sup     = VEC[k][17];
      sdn     = VEC[k][16];
      oe_a_n  = 1'b0;
      oe_b_n  = 1'b0;
      ext_en  = (VEC[k][19:18] == 2'b11);
      ext_val = VEC[k][15:8];
      #2;
      if (VEC[k][19:18] == 2'b11)
        check("R8 outside word intact", pbus, VEC[k][15:8]);
      @(posedge clk);
      #1;
      mode   = 2'b00;
      ext_en = 1'b0;
      clr_n  = 1'b1;
      #1;
      check("R1-R6 vector contents", pbus, VEC[k][7:0]);
      check("R9 end stages", {6'b0, s_hi, s_lo}, {6'b0, VEC[k][7], VEC[k][0]});
    end

    // R7: either enable high releases the bus; moves continue inside
    @(negedge clk);
    oe_a_n = 1'b1; oe_b_n = 1'b0; mode = 2'b00;
    #2 check("R7 oe_a high released", pbus, 8'h00);
    oe_a_n = 1'b0; oe_b_n = 1'b1;
    #2 check("R7 oe_b high released", pbus, 8'h00);
    mode = 2'b01; sup = 1'b0;
    @(posedge clk);
    #1;
    check("R7 still released", pbus, 8'h00);
    check("R9 ends with bus off", {6'b0, s_hi, s_lo}, 8'h02);
    mode = 2'b00; oe_b_n = 1'b0;
    #1 check("R7 moved while released", pbus, 8'hFE);

    // R8: load mode releases the bus before the edge, enables low
    @(negedge clk);
    mode = 2'b11; oe_a_n = 1'b0; oe_b_n = 1'b0; ext_en = 1'b0;
    #2 check("R8 load releases bus", pbus, 8'h00);
    ext_en = 1'b1; ext_val = 8'h5A;
    @(posedge clk);
    #1;
    mode = 2'b00; ext_en = 1'b0;
    #1 check("R4 load after release", pbus, 8'h5A);

    // R10: clear while the bus is enabled in a move mode
    @(negedge clk);
    mode = 2'b01; sup = 1'b1; clr_n = 1'b0;
    @(posedge clk);
    #1;
    check("R10 bus zero after clear", pbus, 8'h00);
    check("R10 ends zero", {6'b0, s_hi, s_lo}, 8'h00);
    @(negedge clk);
    clr_n = 1'b1; mode = 2'b00;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule